// File: doc/BRIEF.md
# Pipelined Microprogram Sequencer

This block produces the control-store address of a microcoded control unit whose microinstructions flow through a decode/operand-fetch stage and then an execute stage. In each cycle it takes the sequencing fields of the microinstruction now being decoded and picks the next address from one of four sources. The sources are the microcounter plus one, the current address field, the address field of the previous microinstruction, and a one-entry return register. The chosen address is registered and drives the control-store address port directly.

A conditional branch on the zero flag cannot be settled while its microinstruction is decoded, because the flag only becomes valid one stage later. The sequencer therefore lets fetch continue down the sequential path and checks the condition in the following cycle. That check compares the delayed polarity bit with the live zero flag. On a mismatch, fetch is redirected to the delayed target. The microinstruction that was fetched on the wrong path is then cancelled, so it can neither arm a late branch nor overwrite the return register.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous reset sets the output address to 0, the return register to 0 and the delayed sequencing code to 01 (no branch). In the first cycle after reset, no redirect happens, whatever the polarity bit and zero flag are.
- R2: When no redirect is taken and the sequencing code is 01 (next) or 11 (late conditional), the next address is the current address plus one, wrapping modulo 2^AW.
- R3: When no redirect is taken, the code is 00 and the mode bit is 0, the next address is the current address field, and the return register captures the current address plus one.
- R4: When no redirect is taken, the code is 00 and the mode bit is 1, the next address is the return register contents.
- R5: When no redirect is taken and the code is 10, the next address is the current address field if the polarity bit is 1, and the current address plus one if it is 0.
- R6: When the previous microinstruction carried code 11 and its polarity bit differs from the current zero flag, the next address is that previous microinstruction's address field, whatever the current fields are.
- R7: When the previous microinstruction carried code 11 and its polarity bit equals the zero flag, the current fields are decoded as in R2 to R5.
- R8: A microinstruction decoded during a taken redirect is cancelled. The following cycle sees a delayed code of 01, so no redirect occurs, and the return register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ca_i | input | AW | Address field of the microinstruction being decoded |
| seq_i | input | 2 | Sequencing code: 00 jump/return, 01 next, 10 branch on polarity, 11 late conditional |
| mi_i | input | 1 | Mode bit: with code 00, 0 selects jump, 1 selects return |
| ps_i | input | 1 | Polarity bit |
| zero_i | input | 1 | Zero status flag from the datapath |
| uaddr_o | output | AW | Registered control-store address |

## Verification
Every decision the sequencer makes, whether an increment, jump, return, polarity branch or late redirect, shows on the address output one clock edge after the inputs that caused it. The bench drives each set of fields at a falling edge, lets one rising edge pass and compares the output at the next falling edge against a bench model that is advanced once per step. The effect of a late branch spans two steps: the code-11 microinstruction is applied in one step and the redirect appears at the end of the next. Cancellation is checked one step after that, and the return register is checked by a later return.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [1:0] {
        SEQ_JUMP = 2'b00,
        SEQ_NEXT = 2'b01,
        SEQ_COND = 2'b10,
        SEQ_LATE = 2'b11
    } seq_code_e;

    typedef enum logic [1:0] {
        SRC_INC    = 2'd0,
        SRC_CA     = 2'd1,
        SRC_CA_DLY = 2'd2,
        SRC_RET    = 2'd3
    } addr_src_e;

    localparam int unsigned NUM_SRC = 4;

endpackage

// File: rtl/useq_select.sv
module useq_select
    import useq_pkg::*;
(
    input  logic [1:0] seq_cur,
    input  logic [1:0] seq_dly,
    input  logic       mi,
    input  logic       ps_cur,
    input  logic       ps_dly,
    input  logic       zero,
    output addr_src_e  src,
    output logic       ret_load,
    output logic       squash
);

    logic late_pend;

    always_comb begin
        late_pend = (seq_dly == SEQ_LATE);
        squash    = late_pend && (ps_dly != zero);
        src       = SRC_INC;
        ret_load  = 1'b0;
        if (squash) begin
            src = SRC_CA_DLY;
        end else begin
            case (seq_cur)
                SEQ_JUMP: begin
                    if (mi) begin
                        src = SRC_RET;
                    end else begin
                        src      = SRC_CA;
                        ret_load = 1'b1;
                    end
                end
                SEQ_COND: src = ps_cur ? SRC_CA : SRC_INC;
                default:  src = SRC_INC;
            endcase
        end
    end

endmodule

// File: rtl/useq_addr_mux.sv
module useq_addr_mux
    import useq_pkg::*;
#(
    parameter int AW = 8
) (
    input  addr_src_e       src,
    input  logic [AW-1:0]   inc_addr,
    input  logic [AW-1:0]   ca,
    input  logic [AW-1:0]   ca_dly,
    input  logic [AW-1:0]   ret_addr,
    output logic [AW-1:0]   nxt
);

    logic [AW-1:0] leg [NUM_SRC];

    always_comb begin
        leg[SRC_INC]    = inc_addr;
        leg[SRC_CA]     = ca;
        leg[SRC_CA_DLY] = ca_dly;
        leg[SRC_RET]    = ret_addr;
        nxt             = leg[src];
    end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ca_i,
    input  logic [1:0]    seq_i,
    input  logic          mi_i,
    input  logic          ps_i,
    input  logic          zero_i,
    output logic [AW-1:0] uaddr_o
);

    localparam logic [AW-1:0] ONE = AW'(1);

    typedef struct packed {
        logic [AW-1:0] mc;
        logic [AW-1:0] ca_p;
        logic [1:0]    seq_p;
        logic          ps_p;
        logic [AW-1:0] ret;
    } state_t;

    state_t        st_d;
    state_t        st_q;
    addr_src_e     src;
    logic          ret_load;
    logic          squash;
    logic [AW-1:0] mc_inc;
    logic [AW-1:0] nxt;

    assign mc_inc = st_q.mc + ONE;

    useq_select u_select (
        .seq_cur  (seq_i),
        .seq_dly  (st_q.seq_p),
        .mi       (mi_i),
        .ps_cur   (ps_i),
        .ps_dly   (st_q.ps_p),
        .zero     (zero_i),
        .src      (src),
        .ret_load (ret_load),
        .squash   (squash)
    );

    useq_addr_mux #(.AW(AW)) u_mux (
        .src      (src),
        .inc_addr (mc_inc),
        .ca       (ca_i),
        .ca_dly   (st_q.ca_p),
        .ret_addr (st_q.ret),
        .nxt      (nxt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.mc    = nxt;
        st_d.ca_p  = ca_i;
        st_d.ps_p  = ps_i;
        st_d.seq_p = squash ? SEQ_NEXT : seq_i;
        if (ret_load) begin
            st_d.ret = mc_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mc    <= '0;
            st_q.ca_p  <= '0;
            st_q.seq_p <= SEQ_NEXT;
            st_q.ps_p  <= 1'b0;
            st_q.ret   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign uaddr_o = st_q.mc;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (uaddr_o == '0 && st_q.seq_p == SEQ_NEXT && st_q.ret == '0)); // R1

    AST_SEQ_INCR: assert property (@(posedge clk) disable iff (rst)
        (st_q.seq_p != SEQ_LATE && seq_i[0]) |=> uaddr_o == $past(uaddr_o) + ONE); // R2

    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (rst)
        (st_q.seq_p != SEQ_LATE && seq_i == SEQ_JUMP && !mi_i)
        |=> (uaddr_o == $past(ca_i) && st_q.ret == $past(uaddr_o) + ONE)); // R3

    AST_RETURN_LOAD: assert property (@(posedge clk) disable iff (rst)
        (st_q.seq_p != SEQ_LATE && seq_i == SEQ_JUMP && mi_i)
        |=> uaddr_o == $past(st_q.ret)); // R4

    AST_COND_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (st_q.seq_p != SEQ_LATE && seq_i == SEQ_COND && ps_i)
        |=> uaddr_o == $past(ca_i)); // R5

    AST_LATE_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (st_q.seq_p == SEQ_LATE && st_q.ps_p != zero_i)
        |=> uaddr_o == $past(st_q.ca_p)); // R6

    AST_CANCEL_SLOT: assert property (@(posedge clk) disable iff (rst)
        (st_q.seq_p == SEQ_LATE && st_q.ps_p != zero_i)
        |=> (st_q.seq_p == SEQ_NEXT && $stable(st_q.ret))); // R8

endmodule

// File: tb/useq_sequencer_tb.sv
module useq_sequencer_tb;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] ca_i;
    logic [1:0]    seq_i;
    logic          mi_i;
    logic          ps_i;
    logic          zero_i;
    logic [AW-1:0] uaddr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [AW-1:0] m_mc, m_ca1, m_ret;
    logic [1:0]    m_mz1;
    logic          m_ps1;

    always #10 clk = ~clk;

    useq_sequencer #(.AW(AW)) u_dut (
        .clk(clk), .rst(rst), .ca_i(ca_i), .seq_i(seq_i),
        .mi_i(mi_i), .ps_i(ps_i), .zero_i(zero_i), .uaddr_o(uaddr_o)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: address actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mc = '0; m_ca1 = '0; m_ret = '0; m_mz1 = 2'b01; m_ps1 = 1'b0;
    endtask

    // Applies one microinstruction at a falling edge and checks the address one rising edge later.
    task automatic step(input logic [AW-1:0] ca, input logic [1:0] mz, input logic mi,
                        input logic ps, input logic z, input string force_tag);
        logic [AW-1:0] n_mc;
        logic [AW-1:0] n_ret;
        logic [1:0]    n_mz1;
        string         tag;
        ca_i = ca; seq_i = mz; mi_i = mi; ps_i = ps; zero_i = z;
        n_ret = m_ret;
        n_mz1 = mz;
        if (m_mz1 == 2'b11 && m_ps1 != z) begin
            n_mc = m_ca1; n_mz1 = 2'b01; tag = "R6";
        end else begin
            case (mz)
                2'b00: if (!mi) begin n_mc = ca; n_ret = m_mc + 1'b1; tag = "R3"; end
                       else begin n_mc = m_ret; tag = "R4"; end
                2'b10: begin n_mc = ps ? ca : m_mc + 1'b1; tag = "R5"; end
                default: begin n_mc = m_mc + 1'b1; tag = "R2"; end
            endcase
            if (m_mz1 == 2'b11) tag = {tag, "/R7"};
        end
        if (force_tag != "") tag = force_tag;
        @(negedge clk);
        check(tag, uaddr_o, n_mc);
        m_mc = n_mc; m_ret = n_ret; m_mz1 = n_mz1; m_ca1 = ca; m_ps1 = ps;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R1", uaddr_o, '0);
    endtask

    initial begin
        void'($urandom(32'h1BADC0DE));
        ca_i = '0; seq_i = 2'b11; mi_i = 1'b0; ps_i = 1'b1; zero_i = 1'b0;
        do_reset();
        // R1: delayed code is no-branch, so a polarity/zero mismatch does not redirect
        step(8'h77, 2'b01, 1'b0, 1'b1, 1'b0, "R1");
        step(8'h00, 2'b01, 1'b0, 1'b0, 1'b0, "R2");
        // R3 then R4: jump records the follow-on address, return comes back
        step(8'h40, 2'b00, 1'b0, 1'b0, 1'b0, "R3");
        step(8'h00, 2'b01, 1'b0, 1'b0, 1'b1, "R2");
        step(8'h00, 2'b00, 1'b1, 1'b0, 1'b0, "R4");
        // R2: wrap from the top address
        step(8'hFF, 2'b00, 1'b0, 1'b0, 1'b0, "R3");
        step(8'h12, 2'b01, 1'b0, 1'b1, 1'b1, "R2");
        // R5: polarity-qualified branch, both polarities
        step(8'h5A, 2'b10, 1'b0, 1'b1, 1'b0, "R5");
        step(8'hA5, 2'b10, 1'b0, 1'b0, 1'b1, "R5");
        // R6 and R8: late branch ps=0,z=1 redirects; the cancelled jump neither arms nor saves
        step(8'h80, 2'b11, 1'b0, 1'b0, 1'b0, "R2");
        step(8'h10, 2'b00, 1'b0, 1'b1, 1'b1, "R6");
        step(8'h00, 2'b01, 1'b0, 1'b0, 1'b0, "R8");
        step(8'h00, 2'b00, 1'b1, 1'b0, 1'b0, "R8");
        // R6: the other mismatch, ps=1,z=0, overriding a current late code
        step(8'hC3, 2'b11, 1'b0, 1'b1, 1'b1, "R2");
        step(8'h3C, 2'b11, 1'b0, 1'b1, 1'b0, "R6");
        step(8'h00, 2'b01, 1'b0, 1'b0, 1'b1, "R8");
        // R7: matching polarity and zero, so the current jump is decoded normally
        step(8'h90, 2'b11, 1'b0, 1'b1, 1'b0, "R2");
        step(8'h33, 2'b00, 1'b0, 1'b0, 1'b1, "R7");
        step(8'h21, 2'b11, 1'b0, 1'b0, 1'b0, "R2");
        step(8'h00, 2'b00, 1'b1, 1'b0, 1'b0, "R7");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] r;
            logic [1:0] mz;
            r  = 3'($urandom % 8);
            mz = (r < 3) ? 2'b01 : (r < 4) ? 2'b00 : (r < 6) ? 2'b10 : 2'b11;
            step(AW'($urandom), mz, 1'($urandom), 1'($urandom), 1'($urandom), "");
        end
        // R1: reset in the middle of a run, with a late branch armed
        step(8'hEE, 2'b11, 1'b0, 1'b1, 1'b0, "R2");
        do_reset();
        step(8'hEE, 2'b01, 1'b0, 1'b0, 1'b1, "R1");
        step(8'h00, 2'b00, 1'b1, 1'b0, 1'b0, "R1");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule